// File: doc/BRIEF.md
# Masked-Compare Translation Lookaside Buffer

This block is a small, fully associative translation buffer. Every slot stores a page-pair number, a per-slot mask that widens the page size, an address-space tag, and two frame halves (even and odd). Each half carries a frame number, a cache attribute, a dirty bit, a valid bit and a global bit. A lookup compares the request against all slots in one cycle. It ignores the page-pair bits that the slot's mask covers, and it skips the address-space check for global slots. The lookup returns the hit flag, the slot index, the fields of the selected half and the translated physical address.

Software-visible maintenance is handled by the surrounding logic through four paths. An indexed write replaces a whole slot. An indexed read returns a slot in packed form. A flush command empties the table. A round-robin next-to-use pointer names the slot to refill, and the read port can follow that pointer. When translation is disabled, the physical address is the virtual address. Independently of translation, a fixed virtual-address pattern marks a request as uncacheable.

Top module: `mask_tlb`

## Requirements
- R1: A slot matches when two conditions hold. First, bits 31..13 of the request address (the page-pair number) equal the slot's stored page-pair number on every bit whose mask bit is 0. Second, either the slot is global or the request address-space tag equals the stored tag.
- R2: A slot can match only if the valid bit of at least one of its halves is 1. A slot whose halves are both invalid never hits.
- R3: When several slots match, the lowest-numbered matching slot is reported.
- R4: The index output is `$clog2(ENTRIES)+1` bits wide. On a miss it is all ones, which is 31 for 16 slots. On a hit it holds the slot number.
- R5: The half is chosen as follows. With k equal to the number of contiguous ones at the bottom of the slot's mask, address bit 12+k selects the half: 0 selects even and 1 selects odd. The hit outputs carry that half's frame number, attribute, dirty and valid bits. The physical address takes the frame number shifted left by 12, with its low 12+k bits replaced by those of the virtual address. On a miss with translation enabled, all of these outputs are 0.
- R6: An indexed write replaces every field of the addressed slot on the next clock edge. A write whose index is not below ENTRIES changes no slot.
- R7: The read port returns the addressed slot in the same cycle. If the write port targets the same slot in that cycle, the read port returns the data being written. An index not below ENTRIES reads as all zeros.
- R8: Each half has the packed layout {frame[19:0] at bits 25..6, attribute at 5..3, dirty at 2, valid at 1, global at 0}. A slot is global only when bit 0 of both halves is 1.
- R9: A flush clears every slot, including all valid bits, and returns the next-to-use pointer to 0 on the next edge. A flush takes precedence over a write in the same cycle.
- R10: The pointer advances by one on each edge where the advance input is 1, wraps from ENTRIES-1 to 0, and otherwise holds. When the pointer-read select is 1, the read port shows the slot the pointer names.
- R11: The uncacheable output is 1 exactly when address bits 31 and 29 are both 1, whether the lookup hits or not.
- R12: When the translation enable is 0, the physical address output equals the virtual address.
- R13: A synchronous active-high reset empties every slot and sets the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlate_en | input | 1 | Translation enable; 0 gives passthrough |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space tag |
| lk_hit | output | 1 | A slot matched |
| lk_index | output | IDXW | Matching slot, all ones on miss |
| lk_pfn | output | 20 | Frame number of the selected half |
| lk_attr | output | 3 | Cache attribute of the selected half |
| lk_dirty | output | 1 | Dirty bit of the selected half |
| lk_valid | output | 1 | Valid bit of the selected half |
| lk_global | output | 1 | Matching slot is global |
| lk_paddr | output | 32 | Physical address |
| lk_uncached | output | 1 | Address falls in the uncacheable pattern |
| wr_en | input | 1 | Indexed write strobe |
| wr_index | input | IDXW | Slot to write |
| wr_vpn | input | 19 | Page-pair number to store |
| wr_mask | input | 19 | Mask to store |
| wr_asid | input | 8 | Address-space tag to store |
| wr_even | input | 26 | Packed even half |
| wr_odd | input | 26 | Packed odd half |
| rd_use_nlu | input | 1 | Read the slot the pointer names |
| rd_index | input | IDXW | Slot to read |
| rd_vpn | output | 19 | Page-pair number read |
| rd_mask | output | 19 | Mask read |
| rd_asid | output | 8 | Address-space tag read |
| rd_even | output | 26 | Packed even half read |
| rd_odd | output | 26 | Packed odd half read |
| flush | input | 1 | Clear all slots and the pointer |
| nlu_adv | input | 1 | Advance the next-to-use pointer |
| nlu_ptr | output | IDXW | Next-to-use pointer |

## Verification
The bench varies masked page-pair bits against unmasked ones, so a compare that ignored the mask would miss. It also checks that a slot is global only when both global bits are set; a design that used only one of the two bits would hit across address spaces. Duplicate matches in slots 2, 9 and 12 expose any encoder that reports the highest or an arbitrary slot. For half selection, a large-page slot is looked up with address bit 14 set and with it clear; a design that tested bit 12 would return the wrong frame and a mis-merged address. An out-of-range write index aliases slot 4 in its low bits, so a design that truncated the index would corrupt slot 4. Same-cycle write/read forwarding, pointer wrap at 15, and flush clearing both the slots and the pointer complete the set.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VADDR_W    = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int VPN_W      = VADDR_W - PAGE_SHIFT - 1;
    localparam int ASID_W     = 8;
    localparam int PFN_W      = 20;
    localparam int ATTR_W     = 3;
    localparam int HALF_W     = PFN_W + ATTR_W + 3;
    localparam int PADDR_W    = PFN_W + PAGE_SHIFT;

    localparam logic [VADDR_W-1:0] UNCACHED_PATTERN = 32'hA000_0000;

    // Packed frame half: frame number on top, global flag in bit 0.
    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              dirty;
        logic              valid;
        logic              glob;
    } half_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  mask;
        logic [ASID_W-1:0] asid;
        half_t             even;
        half_t             odd;
    } entry_t;

    function automatic logic slot_live(input entry_t e);
        return e.even.valid | e.odd.valid;
    endfunction

    function automatic logic slot_global(input entry_t e);
        return e.even.glob & e.odd.glob;
    endfunction

    // Number of contiguous ones at the bottom of a page mask.
    function automatic int trail_ones(input logic [VPN_W-1:0] m);
        int  n;
        logic stop;
        n    = 0;
        stop = 1'b0;
        for (int i = 0; i < VPN_W; i++) begin
            if (!stop) begin
                if (m[i]) n = n + 1;
                else      stop = 1'b1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDXW    = $clog2(ENTRIES) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  entry_t          wr_entry,
    input  logic [IDXW-1:0] rd_idx,
    output entry_t          rd_entry,
    output entry_t          slots [ENTRIES]
);
    localparam int SELW = $clog2(ENTRIES);

    logic rd_in_range;
    logic rd_forward;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                slots[g] <= '0;
            end else if (wr_en && (wr_idx == IDXW'(g))) begin
                slots[g] <= wr_entry;
            end
        end

        // R6: a slot not addressed by the write keeps its contents.
        a_r6_untouched: assert property (@(posedge clk) disable iff (rst)
            (!flush && !(wr_en && (wr_idx == IDXW'(g)))) |=> $stable(slots[g]));

        // R9: after a flush no slot is live.
        a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
            flush |=> !slot_live(slots[g]));
    end

    assign rd_in_range = (int'(rd_idx) < ENTRIES);
    assign rd_forward  = wr_en && !flush && (wr_idx == rd_idx) && rd_in_range;

    always_comb begin
        if (!rd_in_range)    rd_entry = '0;
        else if (rd_forward) rd_entry = wr_entry;
        else                 rd_entry = slots[rd_idx[SELW-1:0]];
    end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDXW    = $clog2(ENTRIES) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  entry_t            slots [ENTRIES],
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    output logic              hit,
    output logic [IDXW-1:0]   idx,
    output entry_t            match_entry
);
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] below;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic tag_ok;
        logic asid_ok;
        assign tag_ok     = (((req_vpn ^ slots[g].vpn) & ~slots[g].mask) == '0);
        assign asid_ok    = slot_global(slots[g]) || (req_asid == slots[g].asid);
        assign hit_vec[g] = slot_live(slots[g]) && tag_ok && asid_ok;
    end

    // Scan from the top so the lowest matching slot is the one kept.
    always_comb begin
        hit         = 1'b0;
        idx         = '1;
        match_entry = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit         = 1'b1;
                idx         = IDXW'(i);
                match_entry = slots[i];
            end
        end
    end

    assign below = (ENTRIES'(1) << idx) - ENTRIES'(1);

    a_r4_miss_index: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (idx == '1));

    a_r4_hit_in_range: assert property (@(posedge clk) disable iff (rst)
        hit |-> (int'(idx) < ENTRIES));

    a_r3_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((hit_vec & below) == '0));

endmodule

// File: rtl/tlb_nlu.sv
module tlb_nlu #(
    parameter int ENTRIES = 16,
    parameter int IDXW    = $clog2(ENTRIES) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            adv,
    output logic [IDXW-1:0] ptr
);
    localparam int SELW = $clog2(ENTRIES);
    localparam logic [SELW-1:0] LAST = SELW'(ENTRIES - 1);

    logic [SELW-1:0] cur;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cur <= '0;
        end else if (adv) begin
            cur <= (cur == LAST) ? '0 : cur + SELW'(1);
        end
    end

    assign ptr = IDXW'(cur);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!adv && !flush) |=> $stable(ptr));

    a_r10_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && !flush && (int'(ptr) == ENTRIES - 1)) |=> (ptr == '0));

    a_r9_ptr_zero: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ptr == '0));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  logic               xlate_en,
    input  logic               hit,
    input  logic [VADDR_W-1:0] vaddr,
    input  entry_t             match_entry,
    output half_t              sel_half,
    output logic [PADDR_W-1:0] paddr,
    output logic               uncached
);
    int                 k;
    logic [VADDR_W-1:0] sel_bit;
    logic [VADDR_W-1:0] off_mask;
    logic [PADDR_W-1:0] base;
    logic               use_odd;

    always_comb begin
        k        = trail_ones(match_entry.mask);
        sel_bit  = VADDR_W'(1) << (PAGE_SHIFT + k);
        off_mask = sel_bit - VADDR_W'(1);
        use_odd  = |(vaddr & sel_bit);
        sel_half = use_odd ? match_entry.odd : match_entry.even;
        base     = {sel_half.pfn, {PAGE_SHIFT{1'b0}}};
        if (!xlate_en)  paddr = vaddr;
        else if (hit)   paddr = (base & ~off_mask) | (vaddr & off_mask);
        else            paddr = '0;
    end

    assign uncached = ((vaddr & UNCACHED_PATTERN) == UNCACHED_PATTERN);

endmodule

// File: rtl/mask_tlb.sv
module mask_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDXW    = $clog2(ENTRIES) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               xlate_en,
    input  logic [VADDR_W-1:0] lk_vaddr,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               lk_hit,
    output logic [IDXW-1:0]    lk_index,
    output logic [PFN_W-1:0]   lk_pfn,
    output logic [ATTR_W-1:0]  lk_attr,
    output logic               lk_dirty,
    output logic               lk_valid,
    output logic               lk_global,
    output logic [PADDR_W-1:0] lk_paddr,
    output logic               lk_uncached,
    input  logic               wr_en,
    input  logic [IDXW-1:0]    wr_index,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [VPN_W-1:0]   wr_mask,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic [HALF_W-1:0]  wr_even,
    input  logic [HALF_W-1:0]  wr_odd,
    input  logic               rd_use_nlu,
    input  logic [IDXW-1:0]    rd_index,
    output logic [VPN_W-1:0]   rd_vpn,
    output logic [VPN_W-1:0]   rd_mask,
    output logic [ASID_W-1:0]  rd_asid,
    output logic [HALF_W-1:0]  rd_even,
    output logic [HALF_W-1:0]  rd_odd,
    input  logic               flush,
    input  logic               nlu_adv,
    output logic [IDXW-1:0]    nlu_ptr
);
    entry_t          slots [ENTRIES];
    entry_t          wr_entry;
    entry_t          rd_entry;
    entry_t          match_entry;
    half_t           sel_half;
    logic [IDXW-1:0] rd_sel;

    assign wr_entry = '{vpn: wr_vpn, mask: wr_mask, asid: wr_asid,
                        even: half_t'(wr_even), odd: half_t'(wr_odd)};
    assign rd_sel   = rd_use_nlu ? nlu_ptr : rd_index;

    tlb_entry_store #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_idx   (wr_index),
        .wr_entry (wr_entry),
        .rd_idx   (rd_sel),
        .rd_entry (rd_entry),
        .slots    (slots)
    );

    tlb_match #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_match (
        .clk         (clk),
        .rst         (rst),
        .slots       (slots),
        .req_vpn     (lk_vaddr[VADDR_W-1:PAGE_SHIFT+1]),
        .req_asid    (lk_asid),
        .hit         (lk_hit),
        .idx         (lk_index),
        .match_entry (match_entry)
    );

    tlb_nlu #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_nlu (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .adv   (nlu_adv),
        .ptr   (nlu_ptr)
    );

    tlb_xlate u_xlate (
        .xlate_en    (xlate_en),
        .hit         (lk_hit),
        .vaddr       (lk_vaddr),
        .match_entry (match_entry),
        .sel_half    (sel_half),
        .paddr       (lk_paddr),
        .uncached    (lk_uncached)
    );

    assign lk_pfn    = sel_half.pfn;
    assign lk_attr   = sel_half.attr;
    assign lk_dirty  = sel_half.dirty;
    assign lk_valid  = sel_half.valid;
    assign lk_global = slot_global(match_entry);

    assign rd_vpn  = rd_entry.vpn;
    assign rd_mask = rd_entry.mask;
    assign rd_asid = rd_entry.asid;
    assign rd_even = rd_entry.even;
    assign rd_odd  = rd_entry.odd;

    // R12: translation off means the address passes through unchanged.
    a_r12_passthrough: assert property (@(posedge clk) disable iff (rst)
        !xlate_en |-> (lk_paddr == lk_vaddr));

endmodule

// File: tb/mask_tlb_bench.sv
`timescale 1ns/1ps
module mask_tlb_bench;
    localparam int ENTRIES = 16;
    localparam int IDXW    = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xlate_en = 1'b1;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit;
    logic [IDXW-1:0] lk_index;
    logic [19:0] lk_pfn;
    logic [2:0]  lk_attr;
    logic        lk_dirty, lk_valid, lk_global;
    logic [31:0] lk_paddr;
    logic        lk_uncached;
    logic        wr_en = 1'b0;
    logic [IDXW-1:0] wr_index = '0;
    logic [18:0] wr_vpn = '0, wr_mask = '0;
    logic [7:0]  wr_asid = '0;
    logic [25:0] wr_even = '0, wr_odd = '0;
    logic        rd_use_nlu = 1'b0;
    logic [IDXW-1:0] rd_index = '0;
    logic [18:0] rd_vpn, rd_mask;
    logic [7:0]  rd_asid;
    logic [25:0] rd_even, rd_odd;
    logic        flush = 1'b0;
    logic        nlu_adv = 1'b0;
    logic [IDXW-1:0] nlu_ptr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mask_tlb #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_mask_tlb (.*);

    function automatic logic [25:0] half(input logic [19:0] pfn, input logic [2:0] attr,
                                         input logic d, input logic v, input logic g);
        return {pfn, attr, d, v, g};
    endfunction

    function automatic logic [31:0] va(input logic [18:0] vpn, input logic odd,
                                       input logic [11:0] off);
        return {vpn, odd, off};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [18:0] vpn, input logic [18:0] mask,
                      input logic [7:0] asid, input logic [25:0] ev, input logic [25:0] od);
        @(negedge clk);
        wr_en = 1'b1; wr_index = IDXW'(idx); wr_vpn = vpn; wr_mask = mask;
        wr_asid = asid; wr_even = ev; wr_odd = od;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] v, input logic [7:0] asid);
        @(negedge clk);
        lk_vaddr = v; lk_asid = asid;
        #1;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        look(va(19'h01234, 1'b0, 12'h123), 8'h05);
        chk("R13 no hit after reset", lk_hit, 0);
        chk("R4 miss index all ones", lk_index, 5'h1F);
        chk("R13 pointer zero", nlu_ptr, 0);
        chk("R5 miss paddr zero", lk_paddr, 0);
    endtask

    task automatic t_basic();
        wr(3, 19'h01234, 19'h0, 8'h05, half(20'hABCDE, 3'd3, 1, 1, 0), half(20'h13579, 3'd2, 0, 1, 0));
        look(va(19'h01234, 1'b0, 12'h123), 8'h05);
        chk("R1 hit", lk_hit, 1);
        chk("R4 index", lk_index, 3);
        chk("R5 even pfn", lk_pfn, 20'hABCDE);
        chk("R8 attr", lk_attr, 3);
        chk("R8 dirty", lk_dirty, 1);
        chk("R5 paddr even", lk_paddr, 32'hABCDE123);
        look(va(19'h01234, 1'b1, 12'h456), 8'h05);
        chk("R5 odd pfn", lk_pfn, 20'h13579);
        chk("R5 odd dirty", lk_dirty, 0);
        chk("R5 paddr odd", lk_paddr, 32'h13579456);
        look(va(19'h01234, 1'b0, 12'h123), 8'h06);
        chk("R1 asid mismatch misses", lk_hit, 0);
        look(va(19'h01235, 1'b0, 12'h123), 8'h05);
        chk("R1 vpn mismatch misses", lk_hit, 0);
    endtask

    task automatic t_global();
        wr(5, 19'h00777, 19'h0, 8'h01, half(20'h11111, 0, 0, 1, 1), half(20'h22222, 0, 0, 1, 1));
        look(va(19'h00777, 1'b0, 12'h0), 8'h99);
        chk("R1 global ignores asid", lk_hit, 1);
        chk("R8 global flag", lk_global, 1);
        wr(6, 19'h00888, 19'h0, 8'h01, half(20'h33333, 0, 0, 1, 1), half(20'h44444, 0, 0, 1, 0));
        look(va(19'h00888, 1'b0, 12'h0), 8'h02);
        chk("R8 one global bit not global", lk_hit, 0);
        look(va(19'h00888, 1'b0, 12'h0), 8'h01);
        chk("R8 non-global asid hit", lk_global, 0);
    endtask

    task automatic t_mask();
        wr(7, 19'h00A00, 19'h3, 8'h09, half(20'h40000, 1, 0, 1, 0), half(20'h50000, 2, 1, 1, 0));
        look(va(19'h00A03, 1'b0, 12'hABC), 8'h09);
        chk("R1 masked bits ignored", lk_hit, 1);
        chk("R5 bit14 set selects odd", lk_pfn, 20'h50000);
        chk("R5 large page paddr odd", lk_paddr, 32'h50002ABC);
        look(va(19'h00A01, 1'b1, 12'hABC), 8'h09);
        chk("R5 bit14 clear selects even", lk_pfn, 20'h40000);
        chk("R5 large page paddr even", lk_paddr, 32'h40003ABC);
        look(va(19'h00A04, 1'b0, 12'h0), 8'h09);
        chk("R1 unmasked bit compared", lk_hit, 0);
    endtask

    task automatic t_priority();
        wr(12, 19'h00321, 19'h0, 8'h03, half(20'hC0000, 0, 0, 1, 0), 26'h0);
        wr(9,  19'h00321, 19'h0, 8'h03, half(20'h90000, 0, 0, 1, 0), 26'h0);
        look(va(19'h00321, 1'b0, 12'h0), 8'h03);
        chk("R3 lower slot wins", lk_index, 9);
        chk("R3 lower slot pfn", lk_pfn, 20'h90000);
        wr(2, 19'h00321, 19'h0, 8'h03, half(20'h20000, 0, 0, 1, 0), 26'h0);
        look(va(19'h00321, 1'b0, 12'h0), 8'h03);
        chk("R3 new lowest slot", lk_index, 2);
    endtask

    task automatic t_valid();
        wr(10, 19'h00555, 19'h0, 8'h04, half(20'h55555, 0, 0, 0, 0), half(20'h66666, 0, 0, 0, 0));
        look(va(19'h00555, 1'b0, 12'h0), 8'h04);
        chk("R2 both invalid misses", lk_hit, 0);
        wr(10, 19'h00555, 19'h0, 8'h04, half(20'h55555, 0, 0, 0, 0), half(20'h66666, 0, 0, 1, 0));
        look(va(19'h00555, 1'b0, 12'h0), 8'h04);
        chk("R2 one valid half hits", lk_hit, 1);
        chk("R5 selected half valid bit", lk_valid, 0);
    endtask

    task automatic t_bounds();
        wr(20, 19'h00666, 19'h0, 8'h01, half(20'h66666, 0, 0, 1, 0), half(20'h66666, 0, 0, 1, 0));
        look(va(19'h00666, 1'b0, 12'h0), 8'h01);
        chk("R6 out-of-range write ignored", lk_hit, 0);
        @(negedge clk); rd_use_nlu = 1'b0; rd_index = 4; #1;
        chk("R6 aliased slot 4 untouched", rd_even, 0);
        rd_index = 20; #1;
        chk("R7 out-of-range read zero", rd_vpn, 0);
        wr(3, 19'h07654, 19'h0, 8'h05, half(20'h77777, 0, 0, 1, 0), 26'h0);
        look(va(19'h01234, 1'b0, 12'h0), 8'h05);
        chk("R6 old contents replaced", lk_hit, 0);
        look(va(19'h07654, 1'b0, 12'h0), 8'h05);
        chk("R6 new contents hit", lk_index, 3);
    endtask

    task automatic t_read();
        @(negedge clk); rd_use_nlu = 1'b0; rd_index = 7; #1;
        chk("R7 read vpn", rd_vpn, 19'h00A00);
        chk("R7 read mask", rd_mask, 19'h3);
        chk("R8 read odd packed", rd_odd, half(20'h50000, 2, 1, 1, 0));
        @(negedge clk);
        wr_en = 1'b1; wr_index = 7; wr_vpn = 19'h01111; wr_mask = 0; wr_asid = 8'h0A;
        wr_even = half(20'h01111, 0, 0, 1, 0); wr_odd = 0;
        #1;
        chk("R7 same-cycle write forwarded", rd_vpn, 19'h01111);
        @(negedge clk); wr_en = 1'b0; #1;
        chk("R7 stored after write", rd_asid, 8'h0A);
    endtask

    task automatic t_flush();
        @(negedge clk); nlu_adv = 1'b1; @(negedge clk); nlu_adv = 1'b0;
        @(negedge clk);
        flush = 1'b1; wr_en = 1'b1; wr_index = 1; wr_vpn = 19'h00999;
        wr_even = half(20'h9, 0, 0, 1, 0); wr_odd = 0; wr_mask = 0; wr_asid = 0;
        @(negedge clk); flush = 1'b0; wr_en = 1'b0;
        look(va(19'h00321, 1'b0, 12'h0), 8'h03);
        chk("R9 flush clears slots", lk_hit, 0);
        look(va(19'h00999, 1'b0, 12'h0), 8'h00);
        chk("R9 flush beats write", lk_hit, 0);
        chk("R9 pointer cleared", nlu_ptr, 0);
        rd_index = 7; #1;
        chk("R9 read after flush", rd_even, 0);
    endtask

    task automatic t_nlu();
        wr(0,  19'h00010, 0, 0, half(20'h10, 0, 0, 1, 0), 0);
        wr(3,  19'h00013, 0, 0, half(20'h13, 0, 0, 1, 0), 0);
        wr(15, 19'h0001F, 0, 0, half(20'h1F, 0, 0, 1, 0), 0);
        @(negedge clk); rd_use_nlu = 1'b1; #1;
        chk("R10 pointer read slot 0", rd_vpn, 19'h00010);
        @(negedge clk); nlu_adv = 1'b1;
        repeat (3) @(negedge clk);
        nlu_adv = 1'b0; #1;
        chk("R10 advance by three", nlu_ptr, 3);
        chk("R10 pointer read slot 3", rd_vpn, 19'h00013);
        repeat (2) @(negedge clk); #1;
        chk("R10 holds without advance", nlu_ptr, 3);
        @(negedge clk); nlu_adv = 1'b1;
        repeat (12) @(negedge clk);
        nlu_adv = 1'b0; #1;
        chk("R10 reaches last slot", rd_vpn, 19'h0001F);
        @(negedge clk); nlu_adv = 1'b1; @(negedge clk); nlu_adv = 1'b0; #1;
        chk("R10 wraps to zero", nlu_ptr, 0);
        rd_use_nlu = 1'b0;
    endtask

    task automatic t_uncached();
        look(32'hA000_0000, 0); chk("R11 both bits set", lk_uncached, 1);
        look(32'hB000_1234, 0); chk("R11 extra bits set", lk_uncached, 1);
        look(32'h8000_0000, 0); chk("R11 only bit 31", lk_uncached, 0);
        look(32'h2000_0000, 0); chk("R11 only bit 29", lk_uncached, 0);
    endtask

    task automatic t_passthrough();
        @(negedge clk); xlate_en = 1'b0;
        look(32'h1234_5678, 0);
        chk("R12 passthrough miss", lk_paddr, 32'h1234_5678);
        look(va(19'h00010, 1'b0, 12'hFFF), 0);
        chk("R12 passthrough on hit", lk_paddr, va(19'h00010, 1'b0, 12'hFFF));
        @(negedge clk); xlate_en = 1'b1; #1;
        chk("R5 translated again", lk_paddr, 32'h0001_0FFF);
    endtask

    task automatic t_reset_mid();
        @(negedge clk); nlu_adv = 1'b1; @(negedge clk); nlu_adv = 1'b0;
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        look(va(19'h00010, 1'b0, 12'h0), 0);
        chk("R13 reset clears slots", lk_hit, 0);
        chk("R13 reset clears pointer", nlu_ptr, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_global();
        t_mask();
        t_priority();
        t_valid();
        t_bounds();
        t_read();
        t_flush();
        t_nlu();
        t_uncached();
        t_passthrough();
        t_reset_mid();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule